// File: doc/BRIEF.md
# Circuit-Switched Node Traffic Endpoint

This block stands in for a processing element hooked to the local port of a circuit-switched on-chip router. Its transmit controller decides at random, with a programmable probability, when to open a connection. It picks a destination and raises a path request. It then waits for the far end to accept or for the network to refuse. A refusal makes it drop the request, sit out a programmable back-off and try again towards the same node. Once accepted, it streams a payload of programmable length and ends with a one-cycle release pulse that tears the path down.

The receive controller serves requests that arrive from the network. When idle it accepts a request and raises clear-to-send. It counts the incoming payload beats and then pulses its own release. One linear-feedback shift register supplies both the start decision and the destination draw. Four counters expose how the transmit side has behaved, so a test environment can build traffic statistics.

Top module: `traffic_endpoint`

## Requirements
- R1: After a synchronous active-low reset, tx_req, tx_valid, tx_release, rx_cts and rx_release are low and all four counters read zero.
- R2: With cfg_act equal to 0 no request is ever raised. With cfg_act all ones a request starts from every idle cycle. For other values a start occurs when the 8-bit random draw is below cfg_act.
- R3: With cfg_restrict high, every requested destination is a node whose bit is set in cfg_target_mask (bit n stands for node n) and is never own_addr. With a single bit set, tx_dest equals that node.
- R4: With cfg_restrict low, every requested destination lies in 0..NODES-1 and differs from own_addr. A draw that fails this test is dropped and redrawn on the next cycle.
- R5: A reject seen while requesting makes tx_req low on the next cycle. It stays low for exactly cfg_retry_delay+1 cycles, then rises again with the same tx_dest. Each reject adds 1 to cnt_rej and cfg_retry_delay+1 to cnt_wait. Every rise of the request adds 1 to cnt_req.
- R6: A request that sees neither grant nor reject stays high for exactly TIMEOUT cycles and is then handled exactly like a reject.
- R7: After a grant, tx_valid is high with tx_req for max(cfg_payload_words,1) consecutive cycles, and tx_data carries the word index 0,1,2,... Then comes one cycle with tx_release high and tx_req low, and cnt_done rises by 1.
- R8: When grant and reject arrive in the same cycle, the reject wins.
- R9: An idle receiver that sees rx_req raises rx_cts on the next cycle and holds it while it receives.
- R10: The receiver counts only cycles with rx_valid high. On the max(cfg_payload_words,1)-th beat, the next cycle shows rx_release high for one cycle with rx_cts low.
- R11: If rx_req falls before the payload completes, rx_cts drops on the next cycle and no rx_release is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| own_addr | input | ADDR_W | Address of this node |
| cfg_restrict | input | 1 | 1: destinations limited to cfg_target_mask |
| cfg_target_mask | input | NODES | Allowed destinations in restricted mode |
| cfg_act | input | 8 | Start probability in 1/256 steps; all ones = always |
| cfg_retry_delay | input | DLY_W | Back-off length after a reject, minus one |
| cfg_payload_words | input | LEN_W | Payload length in words (0 acts as 1) |
| tx_req | output | 1 | Path request / path hold towards the router |
| tx_dest | output | ADDR_W | Requested destination node |
| tx_grant | input | 1 | Destination accepted the path |
| tx_reject | input | 1 | Path refused somewhere on the route |
| tx_valid | output | 1 | Payload word present on tx_data |
| tx_data | output | DATA_W | Payload word (word index) |
| tx_release | output | 1 | One-cycle path tear-down after sending |
| rx_req | input | 1 | Incoming path request |
| rx_valid | input | 1 | Incoming payload beat |
| rx_cts | output | 1 | Clear-to-send to the remote source |
| rx_release | output | 1 | One-cycle tear-down after receiving |
| cnt_req | output | CNT_W | Request attempts raised |
| cnt_rej | output | CNT_W | Rejects and timeouts seen |
| cnt_wait | output | CNT_W | Cycles spent in back-off |
| cnt_done | output | CNT_W | Transfers completed on the transmit side |

## Verification
The bench builds the block with NODES=16 and own_addr 5. It shortens TIMEOUT to 20, so the timeout path fits in a short run, and uses a 4-bit back-off field, so delays 0 to 7 exercise both the immediate retry and longer waits. Restricted mode with one-hot masks makes the destination fully predictable without modelling the random source. Random mode is checked by exclusion (never own, always in range), and a zero-length payload setting exercises the one-word floor.

// File: rtl/tg_pkg.sv
// Shared state encodings for the traffic endpoint.
package tg_pkg;
    typedef enum logic [2:0] {
        TX_IDLE, TX_PICK, TX_REQ, TX_BACKOFF, TX_SEND, TX_REL
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE, RX_RECV, RX_REL
    } rx_state_e;
endpackage

// File: rtl/tg_lfsr.sv
// Galois LFSR free-running every cycle; exposes an activation draw from the
// top bits and a destination draw from the bottom bits.
// Assumes W >= ACT_W, W >= ADDR_W, SEED nonzero, TAPS a maximal polynomial.
module tg_lfsr #(
    parameter int          W      = 16,
    parameter logic [15:0] TAPS   = 16'hB400,
    parameter logic [15:0] SEED   = 16'hACE1,
    parameter int          ACT_W  = 8,
    parameter int          ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ACT_W-1:0]  act_draw,
    output logic [ADDR_W-1:0] dest_draw
);
    logic [W-1:0] st_q;
    logic [W-1:0] st_d;
    logic [W-1:0] taps_w;

    assign taps_w = TAPS[W-1:0];

    // Next-state network: shift right, feed bit 0 back into tapped positions.
    for (genvar b = 0; b < W; b++) begin : g_fb
        if (b == W - 1) begin : g_top
            assign st_d[b] = taps_w[b] & st_q[0];
        end else begin : g_mid
            assign st_d[b] = st_q[b+1] ^ (taps_w[b] & st_q[0]);
        end
    end

    // State register, loaded with the seed on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SEED[W-1:0];
        else        st_q <= st_d;
    end

    assign act_draw  = st_q[W-1 -: ACT_W];
    assign dest_draw = st_q[ADDR_W-1:0];

    // Register never locks up in the all-zero state.
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q != '0);
endmodule

// File: rtl/tg_tx_ctrl.sv
// Transmit controller: start decision, destination pick, request / back-off
// / timeout handling, payload streaming, release, and statistics counters.
// Assumes configuration is held stable while a transfer is in progress and
// that restricted mode has at least one legal target other than own_addr.
module tg_tx_ctrl
    import tg_pkg::*;
#(
    parameter int NODES   = 16,
    parameter int ADDR_W  = 4,
    parameter int ACT_W   = 8,
    parameter int DLY_W   = 4,
    parameter int LEN_W   = 8,
    parameter int DATA_W  = 16,
    parameter int CNT_W   = 16,
    parameter int TIMEOUT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              cfg_restrict,
    input  logic [NODES-1:0]  cfg_target_mask,
    input  logic [ACT_W-1:0]  cfg_act,
    input  logic [DLY_W-1:0]  cfg_retry_delay,
    input  logic [LEN_W-1:0]  cfg_payload_words,
    input  logic [ACT_W-1:0]  act_draw,
    input  logic [ADDR_W-1:0] dest_draw,
    input  logic              tx_grant,
    input  logic              tx_reject,
    output logic              tx_req,
    output logic [ADDR_W-1:0] tx_dest,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_release,
    output logic [CNT_W-1:0]  cnt_req,
    output logic [CNT_W-1:0]  cnt_rej,
    output logic [CNT_W-1:0]  cnt_wait,
    output logic [CNT_W-1:0]  cnt_done
);
    localparam int TMO_W = $clog2(TIMEOUT);

    tx_state_e         state_q;
    logic [ADDR_W-1:0] dest_q;
    logic [TMO_W-1:0]  tmo_q;
    logic [DLY_W-1:0]  bo_q;
    logic [LEN_W-1:0]  widx_q;
    logic [CNT_W-1:0]  req_q, rej_q, wait_q, done_q;

    logic             start_ok;
    logic             in_range;
    logic             cand_ok;
    logic             resp_fail;
    logic [LEN_W:0]   next_idx;
    logic             last_word;

    // Decode of the random draws and of the response conditions.
    always_comb begin
        start_ok  = (cfg_act == '1) || (act_draw < cfg_act);
        in_range  = {1'b0, dest_draw} < (ADDR_W+1)'(NODES);
        cand_ok   = in_range && (dest_draw != own_addr) &&
                    (!cfg_restrict || cfg_target_mask[dest_draw]);
        resp_fail = tx_reject || (tmo_q == TMO_W'(TIMEOUT - 1));
        next_idx  = {1'b0, widx_q} + (LEN_W+1)'(1);
        last_word = next_idx >= {1'b0, cfg_payload_words};
    end

    // Main sequencer with its timers and word index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            dest_q  <= '0;
            tmo_q   <= '0;
            bo_q    <= '0;
            widx_q  <= '0;
        end else begin
            unique case (state_q)
                TX_IDLE: if (start_ok) state_q <= TX_PICK;
                TX_PICK: if (cand_ok) begin
                    dest_q  <= dest_draw;
                    tmo_q   <= '0;
                    state_q <= TX_REQ;
                end
                TX_REQ: begin
                    if (resp_fail) begin
                        bo_q    <= cfg_retry_delay;
                        state_q <= TX_BACKOFF;
                    end else if (tx_grant) begin
                        widx_q  <= '0;
                        state_q <= TX_SEND;
                    end else begin
                        tmo_q <= tmo_q + TMO_W'(1);
                    end
                end
                TX_BACKOFF: begin
                    if (bo_q == '0) begin
                        tmo_q   <= '0;
                        state_q <= TX_REQ;
                    end else begin
                        bo_q <= bo_q - DLY_W'(1);
                    end
                end
                TX_SEND: begin
                    if (last_word) state_q <= TX_REL;
                    else           widx_q  <= widx_q + LEN_W'(1);
                end
                TX_REL:  state_q <= TX_IDLE;
                default: state_q <= TX_IDLE;
            endcase
        end
    end

    // Statistics counters driven by the sequencer's transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= '0;
            rej_q  <= '0;
            wait_q <= '0;
            done_q <= '0;
        end else begin
            if ((state_q == TX_PICK && cand_ok) ||
                (state_q == TX_BACKOFF && bo_q == '0))
                req_q <= req_q + CNT_W'(1);
            if (state_q == TX_REQ && resp_fail)
                rej_q <= rej_q + CNT_W'(1);
            if (state_q == TX_BACKOFF)
                wait_q <= wait_q + CNT_W'(1);
            if (state_q == TX_REL)
                done_q <= done_q + CNT_W'(1);
        end
    end

    assign tx_req     = (state_q == TX_REQ) || (state_q == TX_SEND);
    assign tx_valid   = (state_q == TX_SEND);
    assign tx_release = (state_q == TX_REL);
    assign tx_dest    = dest_q;
    assign tx_data    = DATA_W'(widx_q);
    assign cnt_req    = req_q;
    assign cnt_rej    = rej_q;
    assign cnt_wait   = wait_q;
    assign cnt_done   = done_q;

    // R3
    dest_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && cfg_restrict) |-> cfg_target_mask[tx_dest]);
    // R4
    dest_not_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> (tx_dest != own_addr));
    // R5
    rej_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !tx_valid && tx_reject) |=> !tx_req);
    // R5
    rej_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !tx_valid && tx_reject) |=> (cnt_rej == $past(cnt_rej) + CNT_W'(1)));
    // R7
    valid_holds_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> tx_req);
    // R7
    release_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_release |=> (!tx_release && !tx_req));
endmodule

// File: rtl/tg_rx_ctrl.sv
// Receive controller: accepts an incoming path when idle, raises
// clear-to-send, counts payload beats, then pulses release.
// Assumes the remote source holds rx_req for the whole transfer.
module tg_rx_ctrl
    import tg_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] cfg_payload_words,
    input  logic             rx_req,
    input  logic             rx_valid,
    output logic             rx_cts,
    output logic             rx_release
);
    rx_state_e        state_q;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W:0]   next_cnt;
    logic             last_beat;

    // Beat arithmetic with a one-word floor on the length.
    always_comb begin
        next_cnt  = {1'b0, cnt_q} + (LEN_W+1)'(1);
        last_beat = next_cnt >= {1'b0, cfg_payload_words};
    end

    // Receive sequencer and beat counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                RX_IDLE: if (rx_req) begin
                    cnt_q   <= '0;
                    state_q <= RX_RECV;
                end
                RX_RECV: begin
                    if (!rx_req)                    state_q <= RX_IDLE;
                    else if (rx_valid && last_beat) state_q <= RX_REL;
                    else if (rx_valid)              cnt_q   <= cnt_q + LEN_W'(1);
                end
                RX_REL:  state_q <= RX_IDLE;
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    assign rx_cts     = (state_q == RX_RECV);
    assign rx_release = (state_q == RX_REL);

    // R9
    cts_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_cts) |-> $past(rx_req));
    // R10
    rx_release_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_release |=> !rx_release);
    // R11
    rx_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cts && !rx_req) |=> (!rx_cts && !rx_release));
endmodule

// File: rtl/traffic_endpoint.sv
// Top of the synthetic traffic endpoint: one random source shared by a
// transmit controller and an independent receive controller.
// Assumes NODES <= 2**ADDR_W and the random source is at least as wide as
// both draws.
module traffic_endpoint #(
    parameter int NODES   = 16,
    parameter int DLY_W   = 4,
    parameter int LEN_W   = 8,
    parameter int DATA_W  = 16,
    parameter int CNT_W   = 16,
    parameter int TIMEOUT = 32,
    parameter int RND_W   = 16,
    localparam int ADDR_W = $clog2(NODES),
    localparam int ACT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              cfg_restrict,
    input  logic [NODES-1:0]  cfg_target_mask,
    input  logic [ACT_W-1:0]  cfg_act,
    input  logic [DLY_W-1:0]  cfg_retry_delay,
    input  logic [LEN_W-1:0]  cfg_payload_words,
    output logic              tx_req,
    output logic [ADDR_W-1:0] tx_dest,
    input  logic              tx_grant,
    input  logic              tx_reject,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_release,
    input  logic              rx_req,
    input  logic              rx_valid,
    output logic              rx_cts,
    output logic              rx_release,
    output logic [CNT_W-1:0]  cnt_req,
    output logic [CNT_W-1:0]  cnt_rej,
    output logic [CNT_W-1:0]  cnt_wait,
    output logic [CNT_W-1:0]  cnt_done
);
    logic [ACT_W-1:0]  act_draw;
    logic [ADDR_W-1:0] dest_draw;

    tg_lfsr #(
        .W(RND_W), .ACT_W(ACT_W), .ADDR_W(ADDR_W)
    ) u_rnd (
        .clk(clk), .rst_n(rst_n),
        .act_draw(act_draw), .dest_draw(dest_draw)
    );

    tg_tx_ctrl #(
        .NODES(NODES), .ADDR_W(ADDR_W), .ACT_W(ACT_W), .DLY_W(DLY_W),
        .LEN_W(LEN_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .TIMEOUT(TIMEOUT)
    ) u_tx (
        .clk(clk), .rst_n(rst_n),
        .own_addr(own_addr), .cfg_restrict(cfg_restrict),
        .cfg_target_mask(cfg_target_mask), .cfg_act(cfg_act),
        .cfg_retry_delay(cfg_retry_delay), .cfg_payload_words(cfg_payload_words),
        .act_draw(act_draw), .dest_draw(dest_draw),
        .tx_grant(tx_grant), .tx_reject(tx_reject),
        .tx_req(tx_req), .tx_dest(tx_dest), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_release(tx_release),
        .cnt_req(cnt_req), .cnt_rej(cnt_rej),
        .cnt_wait(cnt_wait), .cnt_done(cnt_done)
    );

    tg_rx_ctrl #(
        .LEN_W(LEN_W)
    ) u_rx (
        .clk(clk), .rst_n(rst_n),
        .cfg_payload_words(cfg_payload_words),
        .rx_req(rx_req), .rx_valid(rx_valid),
        .rx_cts(rx_cts), .rx_release(rx_release)
    );
endmodule

// File: tb/tb_traffic_endpoint.sv
module tb_traffic_endpoint;
    localparam int NODES = 16;
    localparam int TMO   = 20;
    localparam int OWN   = 5;
    localparam int NV    = 6;

    // Vector table: mode, target, back-off, payload words, rejects to inject.
    localparam int V_RESTR[NV] = '{1, 1, 0, 1, 0, 1};
    localparam int V_TGT[NV]   = '{3, 12, 0, 0, 0, 15};
    localparam int V_DLY[NV]   = '{2, 0, 5, 1, 3, 7};
    localparam int V_WRD[NV]   = '{4, 1, 3, 0, 6, 2};
    localparam int V_REJ[NV]   = '{1, 0, 2, 0, 0, 3};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0]  own_addr = 4'(OWN);
    logic        cfg_restrict = 1'b0;
    logic [15:0] cfg_target_mask = '1;
    logic [7:0]  cfg_act = 8'd0;
    logic [3:0]  cfg_retry_delay = 4'd0;
    logic [7:0]  cfg_payload_words = 8'd1;
    logic        tx_grant = 1'b0, tx_reject = 1'b0;
    logic        rx_req = 1'b0, rx_valid = 1'b0;
    logic        tx_req, tx_valid, tx_release, rx_cts, rx_release;
    logic [3:0]  tx_dest;
    logic [15:0] tx_data, cnt_req, cnt_rej, cnt_wait, cnt_done;

    int total = 0;
    int bad = 0;
    longint e_req = 0, e_rej = 0, e_wait = 0, e_done = 0;

    always #5 clk = ~clk;

    traffic_endpoint #(.NODES(NODES), .TIMEOUT(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .own_addr(own_addr),
        .cfg_restrict(cfg_restrict), .cfg_target_mask(cfg_target_mask),
        .cfg_act(cfg_act), .cfg_retry_delay(cfg_retry_delay),
        .cfg_payload_words(cfg_payload_words),
        .tx_req(tx_req), .tx_dest(tx_dest), .tx_grant(tx_grant),
        .tx_reject(tx_reject), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_release(tx_release), .rx_req(rx_req), .rx_valid(rx_valid),
        .rx_cts(rx_cts), .rx_release(rx_release),
        .cnt_req(cnt_req), .cnt_rej(cnt_rej), .cnt_wait(cnt_wait),
        .cnt_done(cnt_done)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_req(output int cyc);
        cyc = 0;
        while (!tx_req && cyc < 600) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic chk_counters(input string tag);
        chk(cnt_req == e_req, {tag, " cnt_req"}, cnt_req, e_req);
        chk(cnt_rej == e_rej, {tag, " cnt_rej"}, cnt_rej, e_rej);
        chk(cnt_wait == e_wait, {tag, " cnt_wait"}, cnt_wait, e_wait);
        chk(cnt_done == e_done, {tag, " cnt_done"}, cnt_done, e_done);
    endtask

    // Reject at the current negedge; measure the low window of the request.
    task automatic do_reject(input int dly, input int dest, input bit with_grant, input string tag);
        int low = 0;
        tx_reject = 1'b1;
        tx_grant  = with_grant;
        @(negedge clk);
        tx_reject = 1'b0;
        tx_grant  = 1'b0;
        while (!tx_req && low < 100) begin
            low++;
            @(negedge clk);
        end
        chk(low == dly + 1, {tag, " back-off length"}, low, dly + 1);
        chk(tx_dest == 4'(dest), {tag, " retry keeps dest"}, tx_dest, dest);
        e_req++; e_rej++; e_wait += dly + 1;
    endtask

    // Grant at the current negedge and check payload and release (R7).
    task automatic do_grant(input int words);
        int eff = (words == 0) ? 1 : words;
        tx_grant = 1'b1;
        cfg_act  = 8'd0;
        @(negedge clk);
        tx_grant = 1'b0;
        for (int k = 0; k < eff; k++) begin
            chk(tx_valid && tx_req, "R7 valid with req", {tx_valid, tx_req}, 3);
            chk(tx_data == 16'(k), "R7 word index", tx_data, k);
            @(negedge clk);
        end
        chk(tx_release && !tx_req && !tx_valid, "R7 release cycle", {tx_release, tx_req}, 2);
        @(negedge clk);
        chk(!tx_release, "R7 release single", tx_release, 0);
        e_done++;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int cyc;
        int dst;
        int seen_mask;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!tx_req && !tx_valid && !tx_release && !rx_cts && !rx_release,
            "R1 outputs low", {tx_req, tx_valid, tx_release, rx_cts, rx_release}, 0);
        chk(cnt_req == 0 && cnt_rej == 0 && cnt_wait == 0 && cnt_done == 0,
            "R1 counters zero", cnt_req + cnt_rej + cnt_wait + cnt_done, 0);
        rst_n = 1'b1;

        // R2 activation zero never requests
        cyc = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (tx_req) cyc++;
        end
        chk(cyc == 0, "R2 act=0 silent", cyc, 0);

        // Vector table walk: R3, R4, R5, R7
        for (int v = 0; v < NV; v++) begin
            cfg_restrict      = V_RESTR[v] != 0;
            cfg_target_mask   = V_RESTR[v] != 0 ? 16'(1) << V_TGT[v] : '1;
            cfg_retry_delay   = 4'(V_DLY[v]);
            cfg_payload_words = 8'(V_WRD[v]);
            cfg_act           = 8'hFF;
            wait_req(cyc);
            chk(cyc < 600, "R2 act=all-ones starts", cyc, 0);
            e_req++;
            dst = int'(tx_dest);
            if (V_RESTR[v] != 0)
                chk(dst == V_TGT[v], "R3 restricted dest", dst, V_TGT[v]);
            else
                chk(dst != OWN && dst < NODES, "R4 random dest", dst, -1);
            for (int r = 0; r < V_REJ[v]; r++)
                do_reject(V_DLY[v], dst, 1'b0, "R5");
            do_grant(V_WRD[v]);
            chk_counters("R5 table");
        end

        // R6 timeout treated as reject
        cfg_restrict = 1'b1; cfg_target_mask = 16'h0004;
        cfg_retry_delay = 4'd3; cfg_payload_words = 8'd2; cfg_act = 8'hFF;
        wait_req(cyc);
        cfg_act = 8'd0;
        e_req++;
        cyc = 0;
        while (tx_req && cyc < 200) begin
            cyc++;
            @(negedge clk);
        end
        chk(cyc == TMO, "R6 timeout length", cyc, TMO);
        e_rej++; e_wait += 4; e_req++;
        wait_req(cyc);
        chk(tx_dest == 4'd2, "R6 retry dest", tx_dest, 2);
        do_grant(2);
        chk_counters("R6");

        // R8 reject beats simultaneous grant
        cfg_target_mask = 16'h0200; cfg_retry_delay = 4'd1; cfg_act = 8'hFF;
        wait_req(cyc);
        cfg_act = 8'd0;
        e_req++;
        do_reject(1, 9, 1'b1, "R8");
        do_grant(2);
        chk_counters("R8");

        // R4 many random draws: never own, in range, more than one target seen
        cfg_restrict = 1'b0; cfg_target_mask = '1; cfg_retry_delay = 4'd0;
        cfg_payload_words = 8'd1;
        seen_mask = 0;
        for (int n = 0; n < 20; n++) begin
            cfg_act = 8'hFF;
            wait_req(cyc);
            e_req++;
            chk(tx_dest != 4'(OWN), "R4 never own", tx_dest, -1);
            seen_mask |= 1 << tx_dest;
            do_grant(1);
        end
        chk($countones(seen_mask) > 1, "R4 spread", $countones(seen_mask), 2);
        chk_counters("R4");

        // R9/R10 receive with a gap beat, length 3
        cfg_payload_words = 8'd3;
        rx_req = 1'b1;
        @(negedge clk);
        chk(rx_cts, "R9 cts raised", rx_cts, 1);
        rx_valid = 1'b1; @(negedge clk);
        rx_valid = 1'b0; @(negedge clk);
        chk(rx_cts && !rx_release, "R10 gap ignored", rx_cts, 1);
        rx_valid = 1'b1; @(negedge clk);
        chk(rx_cts && !rx_release, "R10 before last", rx_release, 0);
        @(negedge clk);
        rx_valid = 1'b0; rx_req = 1'b0;
        chk(rx_release && !rx_cts, "R10 release", {rx_release, rx_cts}, 2);
        @(negedge clk);
        chk(!rx_release, "R10 release single", rx_release, 0);

        // R11 source withdraws mid-transfer
        rx_req = 1'b1; @(negedge clk);
        chk(rx_cts, "R11 cts raised", rx_cts, 1);
        rx_valid = 1'b1; @(negedge clk);
        rx_valid = 1'b0; rx_req = 1'b0; @(negedge clk);
        chk(!rx_cts, "R11 cts dropped", rx_cts, 0);
        cyc = 0;
        for (int i = 0; i < 6; i++) begin
            if (rx_release) cyc++;
            @(negedge clk);
        end
        chk(cyc == 0, "R11 no release", cyc, 0);

        // R1 reset in the middle of a request
        cfg_act = 8'hFF;
        wait_req(cyc);
        rst_n = 1'b0; @(negedge clk);
        cfg_act = 8'd0;
        chk(!tx_req && cnt_req == 0 && cnt_done == 0, "R1 mid-run reset",
            cnt_req, 0);
        rst_n = 1'b1;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule